// File: doc/BRIEF.md
# Configuration Access Request Sequencer

This block takes one configuration-space read or write from a requester and turns it into a single request on a simple completion bus. It first checks the target. A request to a nonzero device on the root bus is refused, and the bus never sees it. Otherwise the block picks a local-bus or remote-bus request type, builds the request address, aligns the write data and byte strobe, and raises the start flag. It then polls for the done indication a bounded number of times, with a fixed number of idle cycles between polls. When done arrives, or the polls run out, it decodes the result and delivers one response: a code, an error flag, a posted/non-posted flag and aligned read data.

The sequence runs through named states. IDLE accepts a request (transition *accept*). CHECK either goes to RESPOND (*refuse*) or to CLEAR (*admit*). CLEAR drops the start flag and acknowledges any pending done. ISSUE raises start. POLL goes to RESPOND when it sees done (*complete*) or has used its last poll (*expire*); otherwise it goes to WAIT (*retry*). WAIT counts the gap and returns to POLL (*gap_over*). RESPOND pulses the response and returns to IDLE (*deliver*).

Top module: `cfg_access_seq`

## Requirements
- R1: A request is accepted only in IDLE. `busy` is high from the cycle after acceptance through the response cycle and is low one cycle after the response. A `req_valid` seen while busy is ignored and produces no second response.
- R2: The request type on `bus_type` is 4'h8 for a local read, 4'h9 for a remote read, 4'hA for a local write and 4'hB for a remote write. A request is local when `req_bus` equals `root_bus`.
- R3: When `req_bus` equals `root_bus` and `req_dev` is nonzero, `bus_start` never rises. The response has code 7 (refused) and `rsp_err` 0. Read data is all ones masked to the access size; write data is 0.
- R4: `bus_addr_lo` holds bus in bits 27:20, device in 19:15, function in 14:12 and `req_off & 12'hFFC` in bits 11:0, with bits 31:28 zero. `bus_addr_hi` is zero.
- R5: `req_size` encodes 0 as 1 byte, 1 as 2 bytes and 2 or 3 as 4 bytes. `bus_strobe` is that many ones shifted left by `req_off[1:0]` and cut to 4 bits. `bus_wdata` is `req_wdata` shifted left by 8 times `req_off[1:0]`.
- R6: Before `bus_start` rises, `bus_done_ack` is high for one cycle with `bus_start` low. A done indication left pending from earlier is therefore cleared and does not complete the new request.
- R7: Polls take place 1 + k*(POLL_GAP+1) cycles after start is first seen, for k = 0 to MAX_POLLS-1. If done is not seen by the last poll, the response has code 6 (timeout) with `rsp_err` 1.
- R8: The completion status field is `bus_status[9:7]`. Value 0 gives code 0 (ok), but code 5 with an error when bit 11 is set. Value 4 gives code 3 with an error. Values 3, 5, 6 and 7 give code 4 (unknown) with an error.
- R9: Status 1 gives code 1 and status 2 gives code 2. On a read these carry no error, and the data is 32'hFFFFFFFF or 32'hFFFF0001 respectively. On a write both carry an error.
- R10: Read data (real or substitute) is shifted right by 8 times `req_off[1:0]` and masked to the access size. Error responses and all writes return data 0.
- R11: `rsp_valid` is a single-cycle pulse. `rsp_nonposted` copies `bus_status[10]` of the completion seen, and is 0 for refused and timed-out requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_bus | input | 8 | Bus number of the root (local) bus |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus |
| req_dev | input | 5 | Target device |
| req_func | input | 3 | Target function |
| req_off | input | 12 | Register byte offset |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right aligned |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_code | output | 3 | Outcome code |
| rsp_nonposted | output | 1 | Non-posted flag of the completion |
| rsp_rdata | output | 32 | Aligned, masked read data |
| bus_start | output | 1 | Start flag of the bus request |
| bus_done_ack | output | 1 | Acknowledge of a pending done |
| bus_type | output | 4 | Request type code |
| bus_addr_lo | output | 32 | Request address, low word |
| bus_addr_hi | output | 32 | Request address, high word (zero) |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_strobe | output | 4 | Byte strobe |
| bus_done | input | 1 | Done indication, held until acknowledged |
| bus_status | input | 12 | Completion status word |
| bus_rdata | input | 32 | Completion read data |

## Verification
Two events can land on the same cycle: a completion arriving and the last allowed poll, which is the point where the completion and timeout paths meet. The bench sets the responder latency to exactly (MAX_POLLS-1)*(POLL_GAP+1) cycles and then to one cycle more. The first must give the decoded completion and the second a timeout. The bench also leaves a stale done pending from earlier, carrying a completer-abort status, right as a new request is accepted; the clear step must consume it, so the response reflects the fresh completion.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CLEAR,
        ST_ISSUE,
        ST_POLL,
        ST_WAIT,
        ST_RESPOND
    } seq_state_e;

    typedef enum logic [2:0] {
        RC_OK       = 3'd0,
        RC_UNSUPP   = 3'd1,
        RC_RETRY    = 3'd2,
        RC_ABORT    = 3'd3,
        RC_UNKNOWN  = 3'd4,
        RC_CPL_ERR  = 3'd5,
        RC_TIMEOUT  = 3'd6,
        RC_REFUSED  = 3'd7
    } rsp_code_e;

    localparam logic [31:0] SUBST_UNSUPP = 32'hFFFF_FFFF;
    localparam logic [31:0] SUBST_RETRY  = 32'hFFFF_0001;

    function automatic logic [31:0] size_mask(input logic [1:0] size);
        unique case (size)
            2'd0:    size_mask = 32'h0000_00FF;
            2'd1:    size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgseq_req_build.sv
module cfgseq_req_build
    import cfgseq_pkg::*;
(
    input  logic        write,
    input  logic [7:0]  bus,
    input  logic [4:0]  dev,
    input  logic [2:0]  func,
    input  logic [11:0] off,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    input  logic [7:0]  root_bus,
    output logic        refuse,
    output logic [3:0]  req_type,
    output logic [31:0] addr_lo,
    output logic [3:0]  strobe,
    output logic [31:0] wdata_al
);
    logic       remote;
    logic [3:0] lane_run;

    always_comb begin
        remote   = (bus != root_bus);
        refuse   = !remote && (dev != 5'd0);
        req_type = {2'b10, write, remote};
        addr_lo  = {4'b0000, bus, dev, func, off & 12'hFFC};
        unique case (size)
            2'd0:    lane_run = 4'b0001;
            2'd1:    lane_run = 4'b0011;
            default: lane_run = 4'b1111;
        endcase
        strobe   = lane_run << off[1:0];
        wdata_al = wdata << {off[1:0], 3'b000};
    end

endmodule

// File: rtl/cfgseq_rsp_decode.sv
module cfgseq_rsp_decode
    import cfgseq_pkg::*;
(
    input  logic        write,
    input  logic [1:0]  off,
    input  logic [1:0]  size,
    input  logic [11:0] status,
    input  logic [31:0] rdata,
    output logic [2:0]  code,
    output logic        err,
    output logic        nonposted,
    output logic [31:0] data
);
    logic [2:0]  cpl;
    logic [31:0] raw;
    logic        use_data;
    logic        unused_low;

    assign unused_low = ^status[6:0];

    always_comb begin
        cpl       = status[9:7];
        nonposted = status[10];
        raw       = rdata;
        use_data  = 1'b0;
        unique case (cpl)
            3'd0: begin
                code     = status[11] ? RC_CPL_ERR : RC_OK;
                err      = status[11];
                use_data = !write && !status[11];
            end
            3'd1: begin
                code     = RC_UNSUPP;
                err      = write;
                raw      = SUBST_UNSUPP;
                use_data = !write;
            end
            3'd2: begin
                code     = RC_RETRY;
                err      = write;
                raw      = SUBST_RETRY;
                use_data = !write;
            end
            3'd4: begin
                code = RC_ABORT;
                err  = 1'b1;
            end
            default: begin
                code = RC_UNKNOWN;
                err  = 1'b1;
            end
        endcase
        data = use_data ? ((raw >> {off, 3'b000}) & size_mask(size)) : 32'd0;
    end

    always_comb begin
        if (!write && !err)
            a_r9_read_no_error_code : assert (code <= RC_RETRY)
                else $error("read without error carries an error code");
    end

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
    import cfgseq_pkg::*;
#(
    parameter int MAX_POLLS = 10,
    parameter int POLL_GAP  = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  root_bus,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_func,
    input  logic [11:0] req_off,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [2:0]  rsp_code,
    output logic        rsp_nonposted,
    output logic [31:0] rsp_rdata,
    output logic        bus_start,
    output logic        bus_done_ack,
    output logic [3:0]  bus_type,
    output logic [31:0] bus_addr_lo,
    output logic [31:0] bus_addr_hi,
    output logic [31:0] bus_wdata,
    output logic [3:0]  bus_strobe,
    input  logic        bus_done,
    input  logic [11:0] bus_status,
    input  logic [31:0] bus_rdata
);
    localparam int TRY_W = $clog2(MAX_POLLS + 1);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_POLLS - 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(POLL_GAP - 1);

    seq_state_e state_q, state_d;

    logic        lat_write;
    logic [7:0]  lat_bus;
    logic [4:0]  lat_dev;
    logic [2:0]  lat_func;
    logic [11:0] lat_off;
    logic [1:0]  lat_size;
    logic [31:0] lat_wdata;
    logic [7:0]  lat_root;

    logic [TRY_W-1:0] tries_q;
    logic [GAP_W-1:0] gap_q;

    logic [2:0]  res_code;
    logic        res_err;
    logic        res_np;
    logic [31:0] res_data;

    logic        refuse_w;
    logic [3:0]  type_w;
    logic [31:0] addr_w;
    logic [3:0]  strobe_w;
    logic [31:0] wdata_w;

    logic [2:0]  dec_code;
    logic        dec_err;
    logic        dec_np;
    logic [31:0] dec_data;

    cfgseq_req_build u_build (
        .write    (lat_write),
        .bus      (lat_bus),
        .dev      (lat_dev),
        .func     (lat_func),
        .off      (lat_off),
        .size     (lat_size),
        .wdata    (lat_wdata),
        .root_bus (lat_root),
        .refuse   (refuse_w),
        .req_type (type_w),
        .addr_lo  (addr_w),
        .strobe   (strobe_w),
        .wdata_al (wdata_w)
    );

    cfgseq_rsp_decode u_decode (
        .write     (lat_write),
        .off       (lat_off[1:0]),
        .size      (lat_size),
        .status    (bus_status),
        .rdata     (bus_rdata),
        .code      (dec_code),
        .err       (dec_err),
        .nonposted (dec_np),
        .data      (dec_data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_CHECK;
            ST_CHECK:   state_d = refuse_w ? ST_RESPOND : ST_CLEAR;
            ST_CLEAR:   state_d = ST_ISSUE;
            ST_ISSUE:   state_d = ST_POLL;
            ST_POLL: begin
                if (bus_done || tries_q == LAST_TRY) state_d = ST_RESPOND;
                else                                 state_d = ST_WAIT;
            end
            ST_WAIT:    if (gap_q == '0) state_d = ST_POLL;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_bus   <= '0;
            lat_dev   <= '0;
            lat_func  <= '0;
            lat_off   <= '0;
            lat_size  <= '0;
            lat_wdata <= '0;
            lat_root  <= '0;
            tries_q   <= '0;
            gap_q     <= '0;
            res_code  <= RC_OK;
            res_err   <= 1'b0;
            res_np    <= 1'b0;
            res_data  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_write <= req_write;
                        lat_bus   <= req_bus;
                        lat_dev   <= req_dev;
                        lat_func  <= req_func;
                        lat_off   <= req_off;
                        lat_size  <= req_size;
                        lat_wdata <= req_wdata;
                        lat_root  <= root_bus;
                    end
                end
                ST_CHECK: begin
                    if (refuse_w) begin
                        res_code <= RC_REFUSED;
                        res_err  <= 1'b0;
                        res_np   <= 1'b0;
                        res_data <= lat_write ? 32'd0 : size_mask(lat_size);
                    end
                end
                ST_CLEAR: tries_q <= '0;
                ST_POLL: begin
                    if (bus_done) begin
                        res_code <= dec_code;
                        res_err  <= dec_err;
                        res_np   <= dec_np;
                        res_data <= dec_data;
                    end else if (tries_q == LAST_TRY) begin
                        res_code <= RC_TIMEOUT;
                        res_err  <= 1'b1;
                        res_np   <= 1'b0;
                        res_data <= '0;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                        gap_q   <= GAP_LOAD;
                    end
                end
                ST_WAIT: gap_q <= gap_q - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy          = (state_q != ST_IDLE);
        rsp_valid     = (state_q == ST_RESPOND);
        rsp_err       = res_err;
        rsp_code      = res_code;
        rsp_nonposted = res_np;
        rsp_rdata     = res_data;
        bus_start     = (state_q == ST_ISSUE) || (state_q == ST_POLL) || (state_q == ST_WAIT);
        bus_done_ack  = (state_q == ST_CLEAR);
        bus_type      = type_w;
        bus_addr_lo   = addr_w;
        bus_addr_hi   = 32'd0;
        bus_wdata     = wdata_w;
        bus_strobe    = strobe_w;
    end

    a_r1_busy_through_rsp : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);
    a_r1_idle_after_rsp : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy);
    a_r11_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r3_refused_not_issued : assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> !(lat_bus == lat_root && lat_dev != 5'd0));
    a_r6_ack_without_start : assert property (@(posedge clk) disable iff (!rst_n)
        bus_done_ack |-> !bus_start);
    a_r6_ack_before_start : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_start) |-> $past(bus_done_ack));
    a_r4_addr_steady : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && $past(bus_start)) |-> ($stable(bus_addr_lo) && bus_addr_hi == 32'd0));
    a_r2_type_range : assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> (bus_type[3:2] == 2'b10));
    a_r7_poll_bound : assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tries_q <= LAST_TRY));

endmodule

// File: tb/tb_cfg_access_seq.sv
module tb_cfg_access_seq;
    localparam int MP = 10;
    localparam int GP = 4;
    localparam int EDGE_LAT = (MP - 1) * (GP + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  root_bus = 8'd3;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_err, rsp_nonposted;
    logic [2:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        bus_start, bus_done_ack;
    logic [3:0]  bus_type, bus_strobe;
    logic [31:0] bus_addr_lo, bus_addr_hi, bus_wdata;
    logic        done_r = 1'b0;
    logic [11:0] st_r = '0;
    logic [31:0] rd_r = '0;

    always #10 clk = ~clk;

    cfg_access_seq #(.MAX_POLLS(MP), .POLL_GAP(GP)) dut (
        .clk(clk), .rst_n(rst_n), .root_bus(root_bus),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_code(rsp_code), .rsp_nonposted(rsp_nonposted), .rsp_rdata(rsp_rdata),
        .bus_start(bus_start), .bus_done_ack(bus_done_ack), .bus_type(bus_type),
        .bus_addr_lo(bus_addr_lo), .bus_addr_hi(bus_addr_hi), .bus_wdata(bus_wdata),
        .bus_strobe(bus_strobe), .bus_done(done_r), .bus_status(st_r), .bus_rdata(rd_r)
    );

    int n_checks = 0, n_fail = 0;

    // responder settings
    int          r_lat = 0;
    bit          r_never = 0;
    logic [11:0] r_stat = '0;
    logic [31:0] r_data = '0;
    bit          stale_req = 0;
    int          r_cnt = 0;
    bit          r_fired = 0;

    // monitor
    bit          m_seen = 0, m_ack = 0, m_bad_order = 0;
    logic [3:0]  m_type, m_strb;
    logic [31:0] m_alo, m_ahi, m_wd;
    int          rsp_cnt = 0;

    always @(posedge clk) begin
        if (bus_done_ack) done_r <= 1'b0;
        else if (stale_req) begin
            done_r <= 1'b1;
            st_r   <= 12'h200;  // completer abort
            rd_r   <= 32'hDEAD_BEEF;
        end else if (bus_start && !r_fired && !r_never && r_cnt == r_lat) begin
            done_r <= 1'b1;
            st_r   <= r_stat;
            rd_r   <= r_data;
        end
        if (!bus_start) begin
            r_cnt   <= 0;
            r_fired <= 0;
        end else if (!r_fired) begin
            r_cnt <= r_cnt + 1;
            if (!r_never && r_cnt == r_lat) r_fired <= 1;
        end

        if (req_valid && !busy) begin
            m_seen <= 0; m_ack <= 0; m_bad_order <= 0;
        end else begin
            if (bus_done_ack) m_ack <= 1;
            if (bus_start && !m_seen) begin
                m_seen <= 1;
                if (!m_ack) m_bad_order <= 1;
                m_type <= bus_type; m_alo <= bus_addr_lo; m_ahi <= bus_addr_hi;
                m_wd <= bus_wdata; m_strb <= bus_strobe;
            end
        end
        if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_mask(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] f_fmt(input logic [31:0] raw, input logic [11:0] o, input logic [1:0] s);
        return (raw >> (8 * o[1:0])) & f_mask(s);
    endfunction

    function automatic logic [3:0] f_strb(input logic [11:0] o, input logic [1:0] s);
        logic [3:0] run;
        run = (s == 2'd0) ? 4'b0001 : (s == 2'd1) ? 4'b0011 : 4'b1111;
        return run << o[1:0];
    endfunction

    // transaction description
    bit          t_write, t_stale, t_junk;
    logic [7:0]  t_bus;
    logic [4:0]  t_dev;
    logic [2:0]  t_func;
    logic [11:0] t_off;
    logic [1:0]  t_size;
    logic [31:0] t_wdata;

    task automatic do_txn();
        bit refused, got;
        logic [2:0] e_code, s;
        bit e_err, e_np;
        logic [31:0] e_data;
        int start_rsp;
        refused = (t_bus == root_bus) && (t_dev != 0);
        s = r_stat[9:7];
        e_np = 0; e_data = 0;
        if (refused) begin
            e_code = 3'd7; e_err = 0; e_data = t_write ? 32'd0 : f_mask(t_size);
        end else if (r_never) begin
            e_code = 3'd6; e_err = 1;
        end else begin
            e_np = r_stat[10];
            case (s)
                3'd0: begin
                    e_code = r_stat[11] ? 3'd5 : 3'd0; e_err = r_stat[11];
                    if (!t_write && !r_stat[11]) e_data = f_fmt(r_data, t_off, t_size);
                end
                3'd1: begin e_code = 3'd1; e_err = t_write;
                    if (!t_write) e_data = f_fmt(32'hFFFF_FFFF, t_off, t_size); end
                3'd2: begin e_code = 3'd2; e_err = t_write;
                    if (!t_write) e_data = f_fmt(32'hFFFF_0001, t_off, t_size); end
                3'd4: begin e_code = 3'd3; e_err = 1; end
                default: begin e_code = 3'd4; e_err = 1; end
            endcase
        end

        if (t_stale) begin
            @(negedge clk); stale_req = 1;
            @(negedge clk); stale_req = 0;
        end
        @(negedge clk);
        start_rsp = rsp_cnt;
        req_write = t_write; req_bus = t_bus; req_dev = t_dev; req_func = t_func;
        req_off = t_off; req_size = t_size; req_wdata = t_wdata; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(busy === 1'b1, "R1 busy after accept", {31'd0, busy}, 32'd1);
        got = 0;
        for (int n = 0; n < 600 && !got; n++) begin
            @(negedge clk);
            if (t_junk && n == 0) begin
                req_valid = 1; req_bus = root_bus; req_dev = 5'd0; req_write = ~t_write;
            end else req_valid = 0;
            if (rsp_valid) got = 1;
        end
        req_valid = 0;
        chk(got, "R1 response delivered", {31'd0, got}, 32'd1);
        chk(rsp_code === e_code, refused ? "R3 refused code" : (r_never ? "R7 timeout code" : "R8 code"),
            {29'd0, rsp_code}, {29'd0, e_code});
        chk(rsp_err === e_err, "R9 error flag", {31'd0, rsp_err}, {31'd0, e_err});
        chk(rsp_rdata === e_data, "R10 read data", rsp_rdata, e_data);
        chk(rsp_nonposted === e_np, "R11 nonposted flag", {31'd0, rsp_nonposted}, {31'd0, e_np});
        if (refused) begin
            chk(!m_seen, "R3 refused request not issued", {31'd0, m_seen}, 32'd0);
        end else begin
            chk(m_seen, "R6 request issued", {31'd0, m_seen}, 32'd1);
            chk(!m_bad_order, "R6 ack before start", {31'd0, m_bad_order}, 32'd0);
            chk(m_type === {2'b10, t_write, t_bus != root_bus}, "R2 request type",
                {28'd0, m_type}, {28'd0, 2'b10, t_write, t_bus != root_bus});
            chk(m_alo === {4'd0, t_bus, t_dev, t_func, t_off & 12'hFFC}, "R4 address low",
                m_alo, {4'd0, t_bus, t_dev, t_func, t_off & 12'hFFC});
            chk(m_ahi === 32'd0, "R4 address high", m_ahi, 32'd0);
            chk(m_strb === f_strb(t_off, t_size), "R5 strobe", {28'd0, m_strb}, {28'd0, f_strb(t_off, t_size)});
            chk(m_wd === (t_wdata << (8 * t_off[1:0])), "R5 write data", m_wd, t_wdata << (8 * t_off[1:0]));
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11 single pulse", {31'd0, rsp_valid}, 32'd0);
        chk(busy === 1'b0, "R1 idle after response", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        chk(rsp_cnt == start_rsp + 1, "R1 junk request ignored", rsp_cnt, start_rsp + 1);
        chk(busy === 1'b0, "R1 still idle", {31'd0, busy}, 32'd0);
    endtask

    task automatic set_ok(input int lat, input logic [11:0] st, input logic [31:0] d);
        r_lat = lat; r_never = 0; r_stat = st; r_data = d;
    endtask

    task automatic set_req(input bit w, input logic [7:0] b, input logic [4:0] d,
                           input logic [11:0] o, input logic [1:0] s);
        t_write = w; t_bus = b; t_dev = d; t_func = 3'd5; t_off = o; t_size = s;
        t_wdata = 32'hA1B2_C3D4; t_stale = 0; t_junk = 0;
    endtask

    initial begin
        #400000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && rsp_valid === 1'b0 && bus_start === 1'b0, "R1 reset state",
            {29'd0, busy, rsp_valid, bus_start}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // directed: refusals at each size
        for (int sz = 0; sz < 3; sz++) begin
            set_req(0, root_bus, 5'd4, 12'h010, sz[1:0]); do_txn();
        end
        set_req(1, root_bus, 5'd1, 12'h010, 2'd2); t_junk = 1; do_txn();
        // directed: last poll boundary
        set_req(0, 8'd9, 5'd2, 12'h102, 2'd1); set_ok(EDGE_LAT, 12'h400, 32'h1234_5678); do_txn();
        set_req(0, 8'd9, 5'd2, 12'h102, 2'd1); set_ok(EDGE_LAT + 1, 12'h000, 32'h1234_5678);
        r_never = 1; do_txn();  // expected timeout (latency beyond last poll)
        set_req(1, 8'd9, 5'd2, 12'h102, 2'd1); set_ok(EDGE_LAT + 1, 12'h000, 0);
        do_txn_timeout_real();
        // directed: UR / CRS on read and write
        set_req(0, root_bus, 0, 12'h003, 2'd0); set_ok(2, 12'h080, 0); do_txn();
        set_req(0, 8'd1, 0, 12'h002, 2'd1); set_ok(2, 12'h100, 0); do_txn();
        set_req(1, root_bus, 0, 12'h000, 2'd2); set_ok(2, 12'h080, 0); do_txn();
        set_req(1, 8'd1, 0, 12'h001, 2'd0); set_ok(2, 12'h100, 0); do_txn();
        // directed: stale done must be cleared
        set_req(0, 8'd7, 5'd3, 12'h0FC, 2'd2); t_stale = 1; set_ok(6, 12'h000, 32'hCAFE_F00D); do_txn();

        for (int i = 0; i < 150; i++) begin
            t_write = $urandom % 2;
            t_bus   = ($urandom % 2) ? root_bus : 8'($urandom);
            t_dev   = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
            t_func  = 3'($urandom);
            t_off   = 12'($urandom);
            t_size  = 2'($urandom);
            t_wdata = $urandom;
            t_stale = ($urandom % 6 == 0);
            t_junk  = ($urandom % 5 == 0);
            r_lat   = $urandom % 20;
            r_never = ($urandom % 16 == 0);
            r_stat  = {1'($urandom % 6 == 0), 1'($urandom), 3'($urandom), 7'd0};
            r_data  = $urandom;
            do_txn();
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // R7: responder fires exactly one cycle after the last poll; must still time out
    task automatic do_txn_timeout_real();
        logic [31:0] e_code;
        int start_rsp;
        @(negedge clk);
        start_rsp = rsp_cnt;
        req_write = t_write; req_bus = t_bus; req_dev = t_dev; req_func = t_func;
        req_off = t_off; req_size = t_size; req_wdata = t_wdata; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        for (int n = 0; n < 600 && !rsp_valid; n++) @(negedge clk);
        e_code = 32'd6;
        chk(rsp_valid === 1'b1, "R7 response at expiry", {31'd0, rsp_valid}, 32'd1);
        chk({29'd0, rsp_code} === e_code, "R7 late completion times out", {29'd0, rsp_code}, e_code);
        chk(rsp_err === 1'b1, "R7 timeout error", {31'd0, rsp_err}, 32'd1);
        @(negedge clk);
        chk(rsp_cnt == start_rsp + 1, "R7 one response", rsp_cnt, start_rsp + 1);
    endtask

endmodule